// File: doc/BRIEF.md
# EEPROM Software Write-Protection Controller

This block sits between a host that drives an asynchronous parallel memory bus (chip enable, output enable and write enable, all active low) and a byte-wide nonvolatile array. It samples the bus on a fast system clock and turns each write-enable falling edge into one write event. The array behind it is modelled by the surrounding logic. The block forwards a write to the array only when protection allows it, and it routes array read data back to the host.

A three-write command sequence turns protection on. A six-write sequence turns it off. Command writes are absorbed and never reach the array. While protection is on, a data write is stored only if the enable sequence came immediately before it. Any other data write is blocked but still starts the internal write-cycle timer. Every write, real or blocked, is followed by the same timing: a page-load window that stays open while writes keep arriving, then the write-cycle time. While that timer runs, further writes are ignored and reads return a polling status word instead of array data.

The protect flag has its own reset input, so resetting the sequencing logic does not clear it.

Top module: `eeprom_wprot_ctrl`

## Requirements
- R1: After reset the block is unprotected and idle. A read returns the array byte at the read address.
- R2: A write event is a falling edge of `we_n` while `ce_n` is low and `oe_n` is high. With protection off, a non-command write stores its byte at its address, and the array strobe pulses one clock after the event.
- R3: Pulling `we_n` low while `oe_n` is low, or while `ce_n` is high, stores nothing.
- R4: Three write events 0xAA@0x1555, 0x55@0x0AAA, 0xA0@0x1555 turn protection on.
- R5: A write that continues the current command sequence, or any 0xAA@0x1555, is never stored. The sequence addresses accept other data as normal writes.
- R6: While protected, a data write not preceded by the enable sequence stores nothing. It starts the write-cycle timer at once.
- R7: While the timer runs, a read returns the last accepted write byte with bit 7 inverted and bit 6 replaced by a flag that flips on every read. Bits 5..0 are that byte's bits 5..0.
- R8: If more than `PAGE_WIN_CYC` cycles pass between command writes, the detector returns to idle. A write that does not match the next step also returns it to idle. Either way, that write is then treated as a data write.
- R9: Six write events 0xAA@0x1555, 0x55@0x0AAA, 0x80@0x1555, 0xAA@0x1555, 0x55@0x0AAA, 0x20@0x1555 turn protection off.
- R10: Write events that occur while the timer runs are ignored. They store nothing and do not change the polling byte.
- R11: Only `flag_rst_n` clears protection. A pulse on `rst_n` leaves it set.
- R12: After a completed enable sequence, data writes that arrive within the page window are stored even though protection is on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the host bus |
| rst_n | input | 1 | Asynchronous active-low reset of sequencing, timer and polling logic |
| flag_rst_n | input | 1 | Asynchronous active-low reset of the protect flag only |
| ce_n | input | 1 | Host chip enable, active low |
| oe_n | input | 1 | Host output enable, active low |
| we_n | input | 1 | Host write enable, active low |
| addr | input | 13 | Host byte address |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data: array byte or polling status |
| arr_we | output | 1 | Array write strobe, one cycle per stored byte |
| arr_waddr | output | 13 | Array write address |
| arr_wdata | output | 8 | Array write data |
| arr_raddr | output | 13 | Array read address |
| arr_rdata | input | 8 | Array read data |

## Verification
A detector stuck in the wrong step shows within a few writes. Either a command byte appears in the array, or a data write that should be stored is blocked and the next read returns polling data. A protect flag in the wrong state shows on the first data write after the timer: that byte is stored or lost against expectation, which the next readback exposes. A timer in the wrong phase shows on the next read, which returns polling data where array data is expected, or the reverse. It also shows on a write that should be ignored but is stored.

// File: rtl/eewp_pkg.sv
package eewp_pkg;

  localparam int ADDR_W = 13;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] KEY_ADDR_HI = 13'h1555;
  localparam logic [ADDR_W-1:0] KEY_ADDR_LO = 13'h0AAA;
  localparam logic [DATA_W-1:0] KEY_FIRST   = 8'hAA;
  localparam logic [DATA_W-1:0] KEY_SECOND  = 8'h55;
  localparam logic [DATA_W-1:0] OP_LOCK     = 8'hA0;
  localparam logic [DATA_W-1:0] OP_PREFREE  = 8'h80;
  localparam logic [DATA_W-1:0] OP_FREE     = 8'h20;

  localparam logic [2:0] STEP_FORK = 3'd2;
  localparam logic [2:0] STEP_LAST = 3'd5;

  typedef enum logic [1:0] {PH_IDLE, PH_LOAD, PH_BUSY} phase_t;

  // does (a,d) continue the sequence from the given step
  function automatic logic step_ok(logic [2:0] step, logic [ADDR_W-1:0] a,
                                   logic [DATA_W-1:0] d);
    case (step)
      3'd0, 3'd3: return (a == KEY_ADDR_HI) && (d == KEY_FIRST);
      3'd1, 3'd4: return (a == KEY_ADDR_LO) && (d == KEY_SECOND);
      3'd2:       return (a == KEY_ADDR_HI) && ((d == OP_LOCK) || (d == OP_PREFREE));
      3'd5:       return (a == KEY_ADDR_HI) && (d == OP_FREE);
      default:    return 1'b0;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] poll_word(logic [DATA_W-1:0] last, logic tog);
    return {~last[7], tog, last[5:0]};
  endfunction

endpackage

// File: rtl/eewp_cmd_detect.sv
module eewp_cmd_detect import eewp_pkg::*; #(
  parameter int PAGE_WIN_CYC = 30000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ok,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic              cmd_hit,
  output logic              lock_done,
  output logic              free_done
);
  localparam int GW = $clog2(PAGE_WIN_CYC + 1);
  localparam logic [GW-1:0] GAP_LIM = GW'(PAGE_WIN_CYC - 1);

  logic [2:0]    step_q, step_d;
  logic [GW-1:0] gap_q;
  logic          cont, restart, gap_out;

  always_comb begin
    cont      = step_ok(step_q, addr, data);
    restart   = (addr == KEY_ADDR_HI) && (data == KEY_FIRST);
    cmd_hit   = wr_ok && (cont || restart);
    lock_done = wr_ok && cont && (step_q == STEP_FORK) && (data == OP_LOCK);
    free_done = wr_ok && cont && (step_q == STEP_LAST);
    gap_out   = (step_q != 3'd0) && (gap_q == GAP_LIM);
    step_d    = step_q;
    if (wr_ok) begin
      if (lock_done || free_done) step_d = 3'd0;
      else if (cont)              step_d = step_q + 3'd1;
      else if (restart)           step_d = 3'd1;
      else                        step_d = 3'd0;
    end else if (gap_out) begin
      step_d = 3'd0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= 3'd0;
      gap_q  <= '0;
    end else begin
      step_q <= step_d;
      if (wr_ok || step_q == 3'd0) gap_q <= '0;
      else if (!gap_out)           gap_q <= gap_q + 1'b1;
    end
  end

  assert_done_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lock_done, free_done}));

  assert_gap_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (gap_out && !wr_ok) |=> (step_q == 3'd0));

endmodule

// File: rtl/eewp_cycle_timer.sv
module eewp_cycle_timer import eewp_pkg::*; #(
  parameter int PAGE_WIN_CYC = 30000,
  parameter int WRITE_CYC    = 2000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick,
  input  logic blocked,
  output logic loading,
  output logic busy
);
  localparam int MAXC = (WRITE_CYC > PAGE_WIN_CYC) ? WRITE_CYC : PAGE_WIN_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] WIN_END = CW'(PAGE_WIN_CYC - 1);
  localparam logic [CW-1:0] WC_LOAD = CW'(WRITE_CYC - 1);

  phase_t        phase_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      case (phase_q)
        PH_IDLE: begin
          if (kick) begin
            phase_q <= PH_LOAD;
            cnt_q   <= '0;
          end else if (blocked) begin
            phase_q <= PH_BUSY;
            cnt_q   <= WC_LOAD;
          end
        end
        PH_LOAD: begin
          if (kick) begin
            cnt_q <= '0;
          end else if (cnt_q == WIN_END) begin
            phase_q <= PH_BUSY;
            cnt_q   <= WC_LOAD;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_BUSY: begin
          if (cnt_q == '0) phase_q <= PH_IDLE;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign loading = (phase_q == PH_LOAD);
  assign busy    = (phase_q == PH_BUSY);

  assert_busy_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt_q <= WC_LOAD));

  assert_window_close_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (loading && !kick && cnt_q == WIN_END) |=> busy);

endmodule

// File: rtl/eewp_poll.sv
module eewp_poll import eewp_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ok,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd_evt,
  input  logic              busy,
  input  logic [DATA_W-1:0] arr_rdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] last_q;
  logic              tog_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= '0;
      tog_q  <= 1'b0;
    end else begin
      if (wr_ok)  last_q <= wdata;
      if (rd_evt) tog_q  <= ~tog_q;
    end
  end

  assign rdata = busy ? poll_word(last_q, tog_q) : arr_rdata;

  assert_toggle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_evt |=> (tog_q != $past(tog_q)));

  assert_last_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(last_q));

endmodule

// File: rtl/eeprom_wprot_ctrl.sv
module eeprom_wprot_ctrl import eewp_pkg::*; #(
  parameter int PAGE_WIN_CYC = 30000,
  parameter int WRITE_CYC    = 2000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flag_rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_waddr,
  output logic [DATA_W-1:0] arr_wdata,
  output logic [ADDR_W-1:0] arr_raddr,
  input  logic [DATA_W-1:0] arr_rdata
);
  logic we_q, oe_q;
  logic wr_evt, rd_evt, wr_ok;
  logic cmd_hit, lock_done, free_done;
  logic loading, busy;
  logic store, blocked, kick;
  logic prot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q <= 1'b1;
      oe_q <= 1'b1;
    end else begin
      we_q <= we_n;
      oe_q <= oe_n;
    end
  end

  assign wr_evt = !ce_n && oe_n && !we_n && we_q;
  assign rd_evt = !ce_n && !oe_n && we_n && oe_q;
  assign wr_ok  = wr_evt && !busy;

  assign store   = wr_ok && !cmd_hit && (!prot_q || loading);
  assign blocked = wr_ok && !cmd_hit && prot_q && !loading;
  assign kick    = store || lock_done || free_done || (cmd_hit && loading);

  eewp_cmd_detect #(.PAGE_WIN_CYC(PAGE_WIN_CYC)) u_detect (
    .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok), .addr(addr), .data(wdata),
    .cmd_hit(cmd_hit), .lock_done(lock_done), .free_done(free_done)
  );

  eewp_cycle_timer #(.PAGE_WIN_CYC(PAGE_WIN_CYC), .WRITE_CYC(WRITE_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .kick(kick), .blocked(blocked),
    .loading(loading), .busy(busy)
  );

  eewp_poll u_poll (
    .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok), .wdata(wdata), .rd_evt(rd_evt),
    .busy(busy), .arr_rdata(arr_rdata), .rdata(rdata)
  );

  // protect flag: survives rst_n, cleared only by its own reset
  always_ff @(posedge clk or negedge flag_rst_n) begin
    if (!flag_rst_n)    prot_q <= 1'b0;
    else if (lock_done) prot_q <= 1'b1;
    else if (free_done) prot_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arr_we    <= 1'b0;
      arr_waddr <= '0;
      arr_wdata <= '0;
    end else begin
      arr_we <= store;
      if (store) begin
        arr_waddr <= addr;
        arr_wdata <= wdata;
      end
    end
  end

  assign arr_raddr = addr;

  assert_no_store_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> !$past(busy));

  assert_cmd_not_stored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> !$past(cmd_hit));

  assert_inhibit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> $past(!ce_n && oe_n && !we_n));

  assert_store_allowed_R12: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> $past(!prot_q || loading));

  assert_blocked_starts_timer_R6: assert property (@(posedge clk) disable iff (!rst_n)
    blocked |=> busy);

  assert_flag_by_command_R11: assert property (@(posedge clk)
    disable iff (!rst_n || !flag_rst_n)
    !$stable(prot_q) |-> $past(lock_done || free_done));

endmodule

// File: tb/eeprom_wprot_ctrl_bench.sv
module eeprom_wprot_ctrl_bench;
  localparam int PW    = 20;
  localparam int WC    = 50;
  localparam int READY = PW + WC + 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0, flag_rst_n = 1'b0;
  logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [12:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        arr_we;
  logic [12:0] arr_waddr, arr_raddr;
  logic [7:0]  arr_wdata, arr_rdata;
  logic [7:0]  mem [0:8191];

  int  checks = 0;
  int  errors = 0;
  bit  finished = 1'b0;

  always #2.5 clk = ~clk;

  eeprom_wprot_ctrl #(.PAGE_WIN_CYC(PW), .WRITE_CYC(WC)) u_eeprom_wprot_ctrl (
    .clk(clk), .rst_n(rst_n), .flag_rst_n(flag_rst_n), .ce_n(ce_n), .oe_n(oe_n),
    .we_n(we_n), .addr(addr), .wdata(wdata), .rdata(rdata), .arr_we(arr_we),
    .arr_waddr(arr_waddr), .arr_wdata(arr_wdata), .arr_raddr(arr_raddr),
    .arr_rdata(arr_rdata)
  );

  assign arr_rdata = mem[arr_raddr];
  always @(posedge clk) if (arr_we) mem[arr_waddr] <= arr_wdata;

  // stimulus vectors: {address, data}, written unprotected then read back
  localparam logic [20:0] VEC [8] = '{
    {13'h0000, 8'h5A}, {13'h1FFF, 8'hC3}, {13'h1555, 8'h12}, {13'h0AAA, 8'h99},
    {13'h0123, 8'h00}, {13'h0800, 8'h7E}, {13'h1554, 8'h81}, {13'h0AAB, 8'hAA}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [12:0] a, input logic [7:0] d,
                    input bit oe_low = 1'b0, input bit ce_high = 1'b0);
    @(negedge clk);
    addr = a; wdata = d; ce_n = ce_high; oe_n = ~oe_low; we_n = 1'b0;
    @(negedge clk);
    we_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic rd(input logic [12:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    @(negedge clk);
    d = rdata;
    oe_n = 1'b1; ce_n = 1'b1;
  endtask

  task automatic seq_lock();
    wr(13'h1555, 8'hAA); wr(13'h0AAA, 8'h55); wr(13'h1555, 8'hA0);
  endtask

  task automatic seq_free();
    wr(13'h1555, 8'hAA); wr(13'h0AAA, 8'h55); wr(13'h1555, 8'h80);
    wr(13'h1555, 8'hAA); wr(13'h0AAA, 8'h55); wr(13'h1555, 8'h20);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] r, r2;
    for (int i = 0; i < 8192; i++) mem[i] = 8'hFF;
    idle(5);
    rst_n = 1'b1; flag_rst_n = 1'b1;
    idle(2);

    // R1: idle after reset, reads pass array data
    rd(13'h0007, r);
    chk("R1 read after reset", r, 8'hFF);

    // R2: table of unprotected writes and readbacks
    for (int i = 0; i < 8; i++) begin
      wr(VEC[i][20:8], VEC[i][7:0]);
      idle(READY);
      rd(VEC[i][20:8], r);
      chk($sformatf("R2 vector %0d", i), r, VEC[i][7:0]);
    end

    // R3: write inhibited by oe low or ce high
    wr(13'h0600, 8'h66, 1'b1, 1'b0);
    wr(13'h0601, 8'h67, 1'b0, 1'b1);
    idle(READY);
    rd(13'h0600, r); chk("R3 oe low inhibits", r, 8'hFF);
    rd(13'h0601, r); chk("R3 ce high inhibits", r, 8'hFF);

    // R8: gap resets detector, so the second step becomes a data write
    wr(13'h1555, 8'hAA);
    idle(PW + 6);
    wr(13'h0AAA, 8'h55);
    idle(READY);
    rd(13'h0AAA, r); chk("R8 gap resets sequence", r, 8'h55);
    // R8: mismatched second step is data
    wr(13'h1555, 8'hAA); wr(13'h0AAA, 8'h56);
    idle(READY);
    rd(13'h0AAA, r); chk("R8 mismatch is data", r, 8'h56);
    rd(13'h1555, r); chk("R5 first key byte not stored", r, 8'h12);

    // R4, R5, R7: enable; command bytes absorbed; polling during timer
    seq_lock();
    idle(PW + 4);
    rd(13'h0000, r);
    chk("R7 poll after enable (bit6 masked)", r & 8'hBF, 8'h20);
    rd(13'h0000, r2);
    chk("R7 bit6 flips per read", {7'b0, r2[6]}, {7'b0, ~r[6]});
    idle(READY);
    rd(13'h1555, r); chk("R5 enable bytes not stored at 0x1555", r, 8'h12);
    rd(13'h0AAA, r); chk("R5 enable bytes not stored at 0x0AAA", r, 8'h56);

    // R6: protected write blocked but timer starts at once
    wr(13'h0100, 8'h3C);
    rd(13'h0100, r);
    chk("R6 blocked write polls (bit6 masked)", r & 8'hBF, 8'hBC);
    idle(READY);
    rd(13'h0100, r); chk("R4 R6 protected write stores nothing", r, 8'hFF);

    // R12: enable then page of data writes is stored
    seq_lock();
    wr(13'h0100, 8'h5A); wr(13'h0101, 8'h6B);
    idle(READY);
    rd(13'h0100, r); chk("R12 unlocked write 0", r, 8'h5A);
    rd(13'h0101, r); chk("R12 unlocked write 1", r, 8'h6B);
    wr(13'h0100, 8'h00);
    idle(READY);
    rd(13'h0100, r); chk("R6 protection still on after page", r, 8'h5A);

    // R9: disable sequence
    seq_free();
    idle(READY);
    wr(13'h0300, 8'h44);
    idle(READY);
    rd(13'h0300, r); chk("R9 unprotected after disable", r, 8'h44);
    rd(13'h1555, r); chk("R5 disable bytes not stored", r, 8'h12);

    // R10: writes during the timer are ignored
    wr(13'h0500, 8'h11);
    idle(PW + 4);
    wr(13'h0501, 8'h22);
    rd(13'h0501, r);
    chk("R10 poll keeps first byte (bit6 masked)", r & 8'hBF, 8'h91);
    idle(READY);
    rd(13'h0501, r); chk("R10 busy write ignored", r, 8'hFF);
    rd(13'h0500, r); chk("R10 first write stored", r, 8'h11);

    // R11: flag survives logic reset, cleared by its own reset
    seq_lock();
    idle(READY);
    @(negedge clk); rst_n = 1'b0;
    idle(3); rst_n = 1'b1;
    idle(2);
    wr(13'h0400, 8'h9D);
    idle(READY);
    rd(13'h0400, r); chk("R11 flag kept over rst_n", r, 8'hFF);
    @(negedge clk); flag_rst_n = 1'b0; rst_n = 1'b0;
    idle(3); flag_rst_n = 1'b1; rst_n = 1'b1;
    idle(2);
    wr(13'h0400, 8'h9D);
    idle(READY);
    rd(13'h0400, r); chk("R11 flag reset clears protection", r, 8'h9D);

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule